// File: doc/BRIEF.md
# Oscillator Lock Health Monitor

This block watches the acquisition status of a disciplined oscillator's control loop and drives a single built-in-test health level. The status code is a multi-bit word, and the loop is locked only when every bit of it is zero. An alarm input overrides the code. The health level `fault_out` is high from reset and stays high while the loop is unlocked. It drops only after the lock has held without a break for a qualification window. Once lock is qualified, any bad input raises the level again at the next clock edge.

The block also runs a longer timer that starts when the lock is acquired. When the lock has held without a break for the save period, the block issues a single-cycle `save_req` pulse. This pulse asks for the loop's tuning set points to be written to non-volatile memory. A one-second time base is divided from the system clock, and `CLKS_PER_SEC` gives its length in cycles.

The controller has four states:
- `ST_UNLOCKED` (reset state): fault high.
- `ST_QUALIFY`: the hold-off is running and the fault is still high.
- `ST_LOCK_FRESH`: locked, with no save yet.
- `ST_LOCK_STORED`: locked, with the save already requested.

Its transitions are:
- UNLOCKED→QUALIFY when a good input is sampled.
- QUALIFY→LOCK_FRESH when the hold-off expires.
- LOCK_FRESH→LOCK_STORED when the save period expires. This edge emits `save_req`.
- Any state other than UNLOCKED returns to UNLOCKED on a bad input.

Top module: `lock_health_monitor`

## Requirements
- R1: While reset is asserted, and after it until lock is qualified, `fault_out` is 1 and `save_req` is 0.
- R2: The loop counts as locked only when `status_code` is all zeros. Any non-zero code, including a code with only one bit set, keeps `fault_out` at 1.
- R3: If good input (status zero, alarm low) is first sampled at clock edge E0 and stays good, `fault_out` is still 1 after edge E0+HOLD_SEC*CLKS_PER_SEC-1 and is 0 after edge E0+HOLD_SEC*CLKS_PER_SEC.
- R4: Once lock is qualified, a non-zero `status_code` sampled at an edge makes `fault_out` 1 right after that same edge.
- R5: `alarm_in` = 1 takes priority over a zero status code. It is treated as loss of lock and raises `fault_out` right after the edge that samples it.
- R6: A bad input during the hold-off sends the block back to unlocked. The next good sample starts a full new hold-off window.
- R7: If good input is first sampled at edge E0 and stays good, `save_req` is 1 for exactly the one cycle after edge E0+SAVE_SEC*CLKS_PER_SEC, and 0 at every other time.
- R8: A loss of lock before the save period ends cancels the pending save. The save timer restarts from the next acquisition edge.
- R9: At most one `save_req` pulse is issued per unbroken lock interval. The block stays quiet for as long as the lock then continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_code | input | STATUS_W | Acquisition status from the control loop; zero means locked |
| alarm_in | input | 1 | Alarm; 1 forces the unlocked state |
| fault_out | output | 1 | Health level: 1 unhealthy or unlocked, 0 locked and healthy |
| save_req | output | 1 | One-cycle request to store the tuning set points |

## Verification
The assertions assume that `status_code` and `alarm_in` are already synchronous to `clk` and hold steady around each rising edge. Under that assumption, the cycle a value is sampled is well defined, and the hold-off and save windows can be measured in whole cycles of unbroken good input. The checker keeps its own count of those cycles. The bench meets the assumption by changing inputs only on falling edges. It counts falling edges from the drive of a good code, which predicts the exact cycle in which `fault_out` drops and `save_req` pulses.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

    typedef enum logic [1:0] {
        ST_UNLOCKED    = 2'd0,
        ST_QUALIFY     = 2'd1,
        ST_LOCK_FRESH  = 2'd2,
        ST_LOCK_STORED = 2'd3
    } lhm_state_e;

    function automatic logic is_locked_state(input lhm_state_e st);
        return (st == ST_LOCK_FRESH) || (st == ST_LOCK_STORED);
    endfunction

endpackage

// File: rtl/lhm_input_qual.sv
// Decides per cycle whether the loop inputs describe a healthy lock.
module lhm_input_qual #(
    parameter int STATUS_W = 4
) (
    input  logic [STATUS_W-1:0] status_code,
    input  logic                alarm_in,
    output logic                lock_ok
);
    // Alarm wins over any status value.
    always_comb begin
        if (alarm_in) begin
            lock_ok = 1'b0;
        end else begin
            lock_ok = (status_code == '0);
        end
    end
endmodule

// File: rtl/lhm_sec_tick.sv
// Divides the system clock into a one-second tick, re-phased on clear.
module lhm_sec_tick #(
    parameter int CLKS_PER_SEC = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SEC - 1);

    logic [CW-1:0] cyc_q;

    assign tick = !clr && (cyc_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cyc_q <= '0;
        end else if (tick) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/lhm_sec_count.sv
// Counts whole seconds of unbroken lock and flags the two milestones.
module lhm_sec_count #(
    parameter int HOLD_SEC = 5,
    parameter int SAVE_SEC = 102
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic hold_hit,
    output logic save_hit
);
    localparam int SW = $clog2(SAVE_SEC + 1);
    localparam logic [SW-1:0] HOLD_LAST = SW'(HOLD_SEC - 1);
    localparam logic [SW-1:0] SAVE_LAST = SW'(SAVE_SEC - 1);
    localparam logic [SW-1:0] SAT       = SW'(SAVE_SEC);

    logic [SW-1:0] sec_q;

    // A milestone fires on the tick that completes the last second.
    assign hold_hit = tick && (sec_q == HOLD_LAST);
    assign save_hit = tick && (sec_q == SAVE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sec_q <= '0;
        end else if (tick && (sec_q != SAT)) begin
            sec_q <= sec_q + 1'b1;
        end
    end
endmodule

// File: rtl/lhm_fsm.sv
// Lock state machine with registered health and save-request outputs.
module lhm_fsm
    import lhm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_ok,
    input  logic       hold_hit,
    input  logic       save_hit,
    output lhm_state_e state,
    output logic       fault_out,
    output logic       save_req
);
    lhm_state_e state_q;
    lhm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOCKED: begin
                if (lock_ok) state_d = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (!lock_ok)     state_d = ST_UNLOCKED;
                else if (hold_hit) state_d = ST_LOCK_FRESH;
            end
            ST_LOCK_FRESH: begin
                if (!lock_ok)     state_d = ST_UNLOCKED;
                else if (save_hit) state_d = ST_LOCK_STORED;
            end
            ST_LOCK_STORED: begin
                if (!lock_ok) state_d = ST_UNLOCKED;
            end
            default: state_d = ST_UNLOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register, driven from the next state so outputs match the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_out <= 1'b1;
            save_req  <= 1'b0;
        end else begin
            fault_out <= !is_locked_state(state_d);
            save_req  <= (state_q == ST_LOCK_FRESH) && (state_d == ST_LOCK_STORED);
        end
    end

    assign state = state_q;
endmodule

// File: rtl/lock_health_monitor.sv
module lock_health_monitor
    import lhm_pkg::*;
#(
    parameter int STATUS_W     = 4,
    parameter int CLKS_PER_SEC = 125_000_000,
    parameter int HOLD_SEC     = 5,
    parameter int SAVE_SEC     = 102
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_code,
    input  logic                alarm_in,
    output logic                fault_out,
    output logic                save_req
);
    logic       lock_ok;
    logic       timer_clr;
    logic       tick;
    logic       hold_hit;
    logic       save_hit;
    lhm_state_e state;

    lhm_input_qual #(.STATUS_W(STATUS_W)) u_qual (
        .status_code (status_code),
        .alarm_in    (alarm_in),
        .lock_ok     (lock_ok)
    );

    // Timers restart on the acquisition edge and on every bad sample.
    assign timer_clr = !lock_ok || (state == ST_UNLOCKED);

    lhm_sec_tick #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .tick  (tick)
    );

    lhm_sec_count #(.HOLD_SEC(HOLD_SEC), .SAVE_SEC(SAVE_SEC)) u_secs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (timer_clr),
        .tick     (tick),
        .hold_hit (hold_hit),
        .save_hit (save_hit)
    );

    lhm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_ok   (lock_ok),
        .hold_hit  (hold_hit),
        .save_hit  (save_hit),
        .state     (state),
        .fault_out (fault_out),
        .save_req  (save_req)
    );
endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
    parameter int STATUS_W     = 4,
    parameter int CLKS_PER_SEC = 125_000_000,
    parameter int HOLD_SEC     = 5,
    parameter int SAVE_SEC     = 102
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] status_code,
    input logic                alarm_in,
    input logic                fault_out,
    input logic                save_req
);
    localparam logic [63:0] HOLD_CYC = 64'(HOLD_SEC) * 64'(CLKS_PER_SEC);
    localparam logic [63:0] SAVE_CYC = 64'(SAVE_SEC) * 64'(CLKS_PER_SEC);

    logic        good_in;
    logic [63:0] good_run;

    assign good_in = (status_code == '0) && !alarm_in;

    // Cycles of unbroken good input sampled since the last bad one.
    always_ff @(posedge clk) begin
        if (!rst_n || !good_in) begin
            good_run <= '0;
        end else if (good_run != '1) begin
            good_run <= good_run + 64'd1;
        end
    end

    // R1
    reset_fault_high_chk: assert property (@(posedge clk)
        !rst_n |=> (fault_out && !save_req));

    // R2
    low_fault_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_out |-> $past(good_in));

    // R3
    holdoff_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_out) |-> (good_run >= HOLD_CYC));

    // R4
    bad_status_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_code != '0) |=> fault_out);

    // R5
    alarm_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_in |=> fault_out);

    // R7
    save_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> !save_req);

    // R8
    save_after_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |-> (good_run >= SAVE_CYC && !fault_out));
endmodule

bind lock_health_monitor lhm_checker #(
    .STATUS_W     (STATUS_W),
    .CLKS_PER_SEC (CLKS_PER_SEC),
    .HOLD_SEC     (HOLD_SEC),
    .SAVE_SEC     (SAVE_SEC)
) u_lhm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_code (status_code),
    .alarm_in    (alarm_in),
    .fault_out   (fault_out),
    .save_req    (save_req)
);

// File: tb/lock_health_monitor_bench.sv
`timescale 1ns/1ps
module lock_health_monitor_bench;
    localparam int SW   = 4;
    localparam int CPS  = 4;
    localparam int HOLD = 5;
    localparam int SAVE = 102;
    localparam int HOLD_K = HOLD * CPS + 1;   // falling edges until fault is low
    localparam int SAVE_K = SAVE * CPS + 1;   // falling edge where save_req is seen

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] status_code;
    logic          alarm_in;
    logic          fault_out;
    logic          save_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lock_health_monitor #(
        .STATUS_W(SW), .CLKS_PER_SEC(CPS), .HOLD_SEC(HOLD), .SAVE_SEC(SAVE)
    ) u_lock_health_monitor (
        .clk(clk), .rst_n(rst_n), .status_code(status_code),
        .alarm_in(alarm_in), .fault_out(fault_out), .save_req(save_req)
    );

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_unlocked();
        status_code = 4'd1;
        alarm_in    = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Drive a good code now; run n falling edges; record when fault first
    // reads low and where save pulses appear.
    task automatic run_good(input int n, output int fault_low_k,
                            output int first_save_k, output int n_saves);
        fault_low_k  = 0;
        first_save_k = 0;
        n_saves      = 0;
        status_code  = '0;
        alarm_in     = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (!fault_out && fault_low_k == 0) fault_low_k = k;
            if (save_req) begin
                n_saves++;
                if (first_save_k == 0) first_save_k = k;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; status_code = '0; alarm_in = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 fault in reset", int'(fault_out), 1);
        check_int("R1 save in reset", int'(save_req), 0);
        status_code = 4'd5;
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check_int("R1 fault after reset, unlocked", int'(fault_out), 1);
        check_int("R1 save after reset", int'(save_req), 0);
    endtask

    task automatic t_nonzero_codes();
        for (int b = 0; b < SW; b++) begin
            int highs = 0;
            status_code = SW'(1) << b;
            for (int k = 0; k < 3 * HOLD_K; k++) begin
                @(negedge clk);
                if (fault_out) highs++;
            end
            check_int("R2 single-bit code keeps fault", highs, 3 * HOLD_K);
        end
    endtask

    task automatic t_qualify();
        int fl, fs, ns;
        go_unlocked();
        run_good(HOLD_K + 5, fl, fs, ns);
        check_int("R3 fault low edge", fl, HOLD_K);
    endtask

    task automatic t_loss();
        status_code = 4'd2;
        @(negedge clk);
        check_int("R4 status loss raises fault", int'(fault_out), 1);
    endtask

    task automatic t_alarm();
        int fl, fs, ns;
        go_unlocked();
        run_good(HOLD_K, fl, fs, ns);
        check_int("R5 locked before alarm", int'(fault_out), 0);
        alarm_in = 1'b1;
        @(negedge clk);
        check_int("R5 alarm raises fault", int'(fault_out), 1);
        repeat (HOLD_K + 3) @(negedge clk);
        check_int("R5 alarm over zero status", int'(fault_out), 1);
        alarm_in = 1'b0;
        run_good(HOLD_K, fl, fs, ns);
        check_int("R5 fresh hold-off after alarm", fl, HOLD_K);
    endtask

    task automatic t_restart();
        int fl, fs, ns;
        go_unlocked();
        status_code = '0;
        repeat (12) @(negedge clk);
        status_code = 4'd3;
        @(negedge clk);
        run_good(HOLD_K + 2, fl, fs, ns);
        check_int("R6 hold-off restarted in full", fl, HOLD_K);
    endtask

    task automatic t_save();
        int fl, fs, ns;
        go_unlocked();
        run_good(SAVE_K + 300, fl, fs, ns);
        check_int("R7 save pulse edge", fs, SAVE_K);
        check_int("R9 one save per lock", ns, 1);
        check_int("R7 still locked", int'(fault_out), 0);
    endtask

    task automatic t_cancel();
        int fl, fs, ns;
        go_unlocked();
        run_good(SAVE_K - 20, fl, fs, ns);
        check_int("R8 no save before period", ns, 0);
        status_code = 4'd8;
        @(negedge clk);
        run_good(SAVE_K + 10, fl, fs, ns);
        check_int("R8 save timed from reacquire", fs, SAVE_K);
        check_int("R8 single pulse after cancel", ns, 1);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-timeout actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        status_code = 4'd1;
        alarm_in    = 1'b0;
        rst_n       = 1'b0;
        @(negedge clk);
        t_reset();
        t_nonzero_codes();
        t_qualify();
        t_loss();
        t_alarm();
        t_restart();
        t_save();
        t_cancel();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule